// File: doc/BRIEF.md
# Two-Way Processor Message Mailbox

The mailbox links an application processor (AP side) with an I/O coprocessor (CP side). It holds two message queues with fixed directions. Queue 0 carries traffic from the AP to the CP, and queue 1 carries traffic from the CP to the AP. Each message is a 96-bit item made of a 64-bit upper part and a 32-bit lower part. Software moves the two parts with two separate accesses.

Both sides get a simple register port, and the address decode behind each port is identical. The direction of a transfer therefore depends on which queue a register belongs to, not on which side makes the access. Each side also drives its own four level-sensitive interrupt lines, which report whether its outgoing queue and its incoming queue are empty or holding data.

A sender reads the full flag in the status register before pushing. A receiver keeps popping while the empty flag is clear. A sender that finds its queue full can wait for the send-empty line. A build parameter removes the per-side interrupt enable register, and the lines are then always enabled.

Top module: `mbx_dual_fifo`

## Requirements
- R1: A message committed to queue 0 or queue 1, from either side, is returned by pops of that same queue in first-in first-out order. The two queues are independent of each other.
- R2: Writing address 2 (queue 0) or address 6 (queue 1) stages a 64-bit upper part in a per-side register. Writing address 3 or 7 commits {staged part, wdata[31:0]} to that queue. Reading address 4 or 8 pops the queue, returns the upper part and latches the lower part. Reading address 5 or 9 returns {32'b0, latched lower part} and does not pop.
- R3: Reading address 0 (queue 0) or address 1 (queue 1) returns status in bits [3:0], with bit 0 = empty, bit 1 = full (DEPTH entries held), bit 2 = underflow and bit 3 = overflow. The upper bits read as zero.
- R4: A commit to a full queue is discarded and leaves the queue contents unchanged. It sets the sticky overflow bit.
- R5: A pop of an empty queue returns zero in both parts and sets the sticky underflow bit. Writing 1 to status bit 2 clears underflow, and writing 1 to bit 3 clears overflow.
- R6: Read data is registered. It appears on rdata after the clock edge that samples the read, and it holds until the next read.
- R7: Each side has four interrupt lines, bit 0 = send-empty, bit 1 = send-not-empty, bit 2 = receive-empty and bit 3 = receive-not-empty. The AP sends on queue 0 and the CP sends on queue 1. A line is high one cycle after its condition holds while its bit in the enable register (address 10, reset 0) is set.
- R8: Writing 1 to a bit of address 11 (acknowledge) drops that line for the following cycle. If its condition still holds, the line asserts again the cycle after that.
- R9: With HAS_IRQ_CTL = 0, the enables are fixed on and address 10 reads 4'hF. Writes to address 10 have no effect.
- R10: A commit from one side and a pop from the other side of the same queue in the same cycle both take effect. If both sides commit to, or both sides pop, the same queue in one cycle, the AP access is served and the CP access is ignored.
- R11: After reset both queues are empty, the sticky bits are clear, the enables are zero and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ap_req_i | input | 1 | AP-side access strobe |
| ap_we_i | input | 1 | AP-side write (1) or read (0) |
| ap_addr_i | input | 4 | AP-side register address |
| ap_wdata_i | input | 64 | AP-side write data |
| ap_rdata_o | output | 64 | AP-side registered read data |
| ap_irq_o | output | 4 | AP-side interrupt lines |
| cp_req_i | input | 1 | CP-side access strobe |
| cp_we_i | input | 1 | CP-side write (1) or read (0) |
| cp_addr_i | input | 4 | CP-side register address |
| cp_wdata_i | input | 64 | CP-side write data |
| cp_rdata_o | output | 64 | CP-side registered read data |
| cp_irq_o | output | 4 | CP-side interrupt lines |

## Verification
Two events can land in the same cycle on one queue. The first is a commit from one side together with a pop from the other side. The bench provokes it by holding the AP lower-part write and the CP upper-part read on the same edge while queue 0 already holds two entries. It then judges the result by the word popped in that cycle and by the order of the two words that follow.

The second collision is two commits to the same queue, one from each side. After it, the queue must hold only the AP message and no overflow bit may be set. An acknowledge that arrives while its condition still holds is judged by the one-cycle dip on the line and the re-assertion right after it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int HI_W  = 64;
  localparam int LO_W  = 32;
  localparam int MSG_W = HI_W + LO_W;
  localparam int ADDR_W = 4;
  localparam int NIRQ  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT0 = 4'd0,
    A_STAT1 = 4'd1,
    A_WHI0  = 4'd2,
    A_WLO0  = 4'd3,
    A_RHI0  = 4'd4,
    A_RLO0  = 4'd5,
    A_WHI1  = 4'd6,
    A_WLO1  = 4'd7,
    A_RHI1  = 4'd8,
    A_RLO1  = 4'd9,
    A_IEN   = 4'd10,
    A_IACK  = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic full;
    logic empty;
  } fifo_stat_t;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     push_data_i,
  input  logic             pop_i,
  input  logic             clr_ovf_i,
  input  logic             clr_unf_i,
  output logic [W-1:0]     head_o,
  output mbx_pkg::fifo_stat_t stat_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ovf_q, ovf_n, unf_q, unf_n;
  logic             empty, full, do_push, do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    do_push = push_i & ~full;
    do_pop  = pop_i & ~empty;
    wr_n    = wr_q;
    rd_n    = rd_q;
    if (do_push) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    cnt_n = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    ovf_n = (push_i & full)  | (ovf_q & ~clr_ovf_i);
    unf_n = (pop_i  & empty) | (unf_q & ~clr_unf_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
      unf_q <= unf_n;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  assign head_o = empty ? '0 : mem_q[rd_q];
  assign stat_o = '{ovf: ovf_q, unf: unf_q, full: full, empty: empty};

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |=> (cnt_q <= $past(cnt_q)));
  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_push_lands_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full) |=> !stat_o.empty);
  assert_pop_frees_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty && !push_i) |=> !stat_o.full);
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter bit HAS_IRQ_CTL = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HI_W-1:0]   wdata_i,
  output logic [HI_W-1:0]   rdata_o,
  input  fifo_stat_t        stat0_i,
  input  fifo_stat_t        stat1_i,
  input  logic [MSG_W-1:0]  head0_i,
  input  logic [MSG_W-1:0]  head1_i,
  input  logic [1:0]        pop_gnt_i,
  input  logic [NIRQ-1:0]   cond_i,
  output logic [1:0]        push_o,
  output logic [1:0]        pop_o,
  output logic [MSG_W-1:0]  push_data_o,
  output logic [1:0]        clr_ovf_o,
  output logic [1:0]        clr_unf_o,
  output logic [NIRQ-1:0]   irq_o
);
  logic            wr, rd;
  reg_addr_e       a;
  logic [HI_W-1:0] stage_q, stage_n, rdata_q, rdata_n;
  logic [LO_W-1:0] lo_q, lo_n;
  logic [NIRQ-1:0] en_q, ack, irq_q, irq_n;

  always_comb begin
    wr  = req_i & we_i;
    rd  = req_i & ~we_i;
    a   = reg_addr_e'(addr_i);
    push_o      = {wr && a == A_WLO1, wr && a == A_WLO0};
    pop_o       = {rd && a == A_RHI1, rd && a == A_RHI0};
    clr_ovf_o   = {wr && a == A_STAT1 && wdata_i[3], wr && a == A_STAT0 && wdata_i[3]};
    clr_unf_o   = {wr && a == A_STAT1 && wdata_i[2], wr && a == A_STAT0 && wdata_i[2]};
    push_data_o = {stage_q, wdata_i[LO_W-1:0]};
    stage_n = (wr && (a == A_WHI0 || a == A_WHI1)) ? wdata_i : stage_q;
    ack     = (wr && a == A_IACK) ? wdata_i[NIRQ-1:0] : '0;
    irq_n   = cond_i & en_q & ~ack;
    rdata_n = rdata_q;
    lo_n    = lo_q;
    if (rd) begin
      rdata_n = '0;
      case (a)
        A_STAT0: rdata_n = HI_W'(stat0_i);
        A_STAT1: rdata_n = HI_W'(stat1_i);
        A_RHI0: begin
          rdata_n = pop_gnt_i[0] ? head0_i[MSG_W-1:LO_W] : '0;
          lo_n    = pop_gnt_i[0] ? head0_i[LO_W-1:0] : '0;
        end
        A_RHI1: begin
          rdata_n = pop_gnt_i[1] ? head1_i[MSG_W-1:LO_W] : '0;
          lo_n    = pop_gnt_i[1] ? head1_i[LO_W-1:0] : '0;
        end
        A_RLO0, A_RLO1: rdata_n = HI_W'(lo_q);
        A_IEN:   rdata_n = HI_W'(en_q);
        default: rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      rdata_q <= '0;
      lo_q    <= '0;
      irq_q   <= '0;
    end else begin
      stage_q <= stage_n;
      rdata_q <= rdata_n;
      lo_q    <= lo_n;
      irq_q   <= irq_n;
    end
  end

  generate
    if (HAS_IRQ_CTL) begin : g_ien
      logic [NIRQ-1:0] en_r, en_n;
      always_comb en_n = (wr && a == A_IEN) ? wdata_i[NIRQ-1:0] : en_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_r <= '0;
        else         en_r <= en_n;
      end
      assign en_q = en_r;
    end else begin : g_no_ien
      assign en_q = '1;
    end
  endgenerate

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  assert_ack_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ack) |=> ((irq_o & $past(ack)) == '0));
  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & ~$past(en_q)) == '0));
  assert_pop_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && a == A_RHI0 && stat0_i.empty) |=> (rdata_o == '0));
  assert_rdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: rtl/mbx_dual_fifo.sv
module mbx_dual_fifo
  import mbx_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter bit HAS_IRQ_CTL = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ap_req_i,
  input  logic        ap_we_i,
  input  logic [3:0]  ap_addr_i,
  input  logic [63:0] ap_wdata_i,
  output logic [63:0] ap_rdata_o,
  output logic [3:0]  ap_irq_o,
  input  logic        cp_req_i,
  input  logic        cp_we_i,
  input  logic [3:0]  cp_addr_i,
  input  logic [63:0] cp_wdata_i,
  output logic [63:0] cp_rdata_o,
  output logic [3:0]  cp_irq_o
);
  logic [1:0]       ap_push, ap_pop, cp_push, cp_pop;
  logic [1:0]       ap_covf, ap_cunf, cp_covf, cp_cunf;
  logic [MSG_W-1:0] ap_pdata, cp_pdata;
  logic [MSG_W-1:0] head [2];
  fifo_stat_t       stat [2];
  logic [1:0]       cp_gnt;

  assign cp_gnt = cp_pop & ~ap_pop;

  generate
    for (genvar f = 0; f < 2; f++) begin : g_q
      mbx_fifo #(.DEPTH(DEPTH), .W(MSG_W)) u_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (ap_push[f] | cp_push[f]),
        .push_data_i (ap_push[f] ? ap_pdata : cp_pdata),
        .pop_i       (ap_pop[f] | cp_pop[f]),
        .clr_ovf_i   (ap_covf[f] | cp_covf[f]),
        .clr_unf_i   (ap_cunf[f] | cp_cunf[f]),
        .head_o      (head[f]),
        .stat_o      (stat[f])
      );
    end
  endgenerate

  mbx_port #(.HAS_IRQ_CTL(HAS_IRQ_CTL)) u_ap (
    .clk_i, .rst_ni,
    .req_i(ap_req_i), .we_i(ap_we_i), .addr_i(ap_addr_i), .wdata_i(ap_wdata_i),
    .rdata_o(ap_rdata_o),
    .stat0_i(stat[0]), .stat1_i(stat[1]), .head0_i(head[0]), .head1_i(head[1]),
    .pop_gnt_i(ap_pop),
    .cond_i({~stat[1].empty, stat[1].empty, ~stat[0].empty, stat[0].empty}),
    .push_o(ap_push), .pop_o(ap_pop), .push_data_o(ap_pdata),
    .clr_ovf_o(ap_covf), .clr_unf_o(ap_cunf), .irq_o(ap_irq_o)
  );

  mbx_port #(.HAS_IRQ_CTL(HAS_IRQ_CTL)) u_cp (
    .clk_i, .rst_ni,
    .req_i(cp_req_i), .we_i(cp_we_i), .addr_i(cp_addr_i), .wdata_i(cp_wdata_i),
    .rdata_o(cp_rdata_o),
    .stat0_i(stat[0]), .stat1_i(stat[1]), .head0_i(head[0]), .head1_i(head[1]),
    .pop_gnt_i(cp_gnt),
    .cond_i({~stat[0].empty, stat[0].empty, ~stat[1].empty, stat[1].empty}),
    .push_o(cp_push), .pop_o(cp_pop), .push_data_o(cp_pdata),
    .clr_ovf_o(cp_covf), .clr_unf_o(cp_cunf), .irq_o(cp_irq_o)
  );

  assert_ap_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_req_i && !ap_we_i && cp_req_i && !cp_we_i && ap_addr_i == cp_addr_i &&
     (ap_addr_i == A_RHI0 || ap_addr_i == A_RHI1)) |=> (cp_rdata_o == '0));
endmodule

// File: tb/tb_mbx_dual_fifo.sv
`timescale 1ns/1ps
module tb_mbx_dual_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req [3];
  logic        we [3];
  logic [3:0]  addr [3];
  logic [63:0] wdata [3];
  logic [63:0] rdata [3];
  logic [3:0]  irq [3];
  logic [63:0] nc_cp_rdata;
  logic [3:0]  nc_cp_irq;
  int nvec = 0, nfail = 0;
  logic [95:0] q0 [$];
  logic [95:0] q1 [$];

  always #2.5 clk = ~clk;

  mbx_dual_fifo dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ap_req_i(req[0]), .ap_we_i(we[0]), .ap_addr_i(addr[0]), .ap_wdata_i(wdata[0]),
    .ap_rdata_o(rdata[0]), .ap_irq_o(irq[0]),
    .cp_req_i(req[1]), .cp_we_i(we[1]), .cp_addr_i(addr[1]), .cp_wdata_i(wdata[1]),
    .cp_rdata_o(rdata[1]), .cp_irq_o(irq[1])
  );

  mbx_dual_fifo #(.HAS_IRQ_CTL(1'b0)) dut_nc (
    .clk_i(clk), .rst_ni(rst_n),
    .ap_req_i(req[2]), .ap_we_i(we[2]), .ap_addr_i(addr[2]), .ap_wdata_i(wdata[2]),
    .ap_rdata_o(rdata[2]), .ap_irq_o(irq[2]),
    .cp_req_i(1'b0), .cp_we_i(1'b0), .cp_addr_i(4'd0), .cp_wdata_i(64'd0),
    .cp_rdata_o(nc_cp_rdata), .cp_irq_o(nc_cp_irq)
  );

  task automatic chk(string tag, logic [95:0] got, logic [95:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bwr(int s, logic [3:0] a, logic [63:0] d);
    @(negedge clk);
    req[s] = 1'b1; we[s] = 1'b1; addr[s] = a; wdata[s] = d;
    @(posedge clk);
    @(negedge clk);
    req[s] = 1'b0; we[s] = 1'b0;
  endtask

  task automatic brd(int s, logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    req[s] = 1'b1; we[s] = 1'b0; addr[s] = a;
    @(posedge clk);
    @(negedge clk);
    req[s] = 1'b0;
    d = rdata[s];
  endtask

  // driver: commits a message and records it as expected when it should land
  task automatic push_msg(int s, int f, logic [95:0] m, bit accept);
    bwr(s, (f != 0) ? 4'd6 : 4'd2, m[95:32]);
    bwr(s, (f != 0) ? 4'd7 : 4'd3, {32'd0, m[31:0]});
    if (accept) begin
      if (f != 0) q1.push_back(m); else q0.push_back(m);
    end
  endtask

  // monitor: pops a message and compares it against the scoreboard
  task automatic pop_chk(int s, int f, string tag);
    logic [63:0] hi, lo, lo2;
    logic [95:0] exp;
    brd(s, (f != 0) ? 4'd8 : 4'd4, hi);
    brd(s, (f != 0) ? 4'd9 : 4'd5, lo);
    brd(s, (f != 0) ? 4'd9 : 4'd5, lo2);
    exp = '0;
    if (f != 0) begin if (q1.size() > 0) exp = q1.pop_front(); end
    else        begin if (q0.size() > 0) exp = q0.pop_front(); end
    chk(tag, {hi, lo[31:0]}, exp);
    chk({tag, " lo reread R2"}, lo2, lo);
  endtask

  task automatic stat_chk(int s, int f, logic [3:0] exp, string tag);
    logic [63:0] d;
    brd(s, 4'(f), d);
    chk(tag, d, {92'd0, exp});
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d;
    for (int i = 0; i < 3; i++) begin
      req[i] = 1'b0; we[i] = 1'b0; addr[i] = '0; wdata[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    chk("R11 ap irq", irq[0], 4'h0);
    chk("R11 cp irq", irq[1], 4'h0);
    stat_chk(0, 0, 4'h1, "R11 R3 stat0 after reset");
    stat_chk(1, 1, 4'h1, "R11 R3 stat1 after reset");

    // R1 R2 AP->CP traffic on queue 0, CP->AP on queue 1
    push_msg(0, 0, 96'h1111_2222_3333_4444_5555_6666, 1);
    push_msg(0, 0, 96'hA5A5_0000_FFFF_1234_DEAD_BEEF, 1);
    push_msg(1, 1, 96'h0F0F_F0F0_0101_1010_CAFE_F00D, 1);
    pop_chk(1, 0, "R1 R2 q0 first");
    pop_chk(1, 0, "R1 R2 q0 second");
    pop_chk(0, 1, "R1 R2 q1 reverse");
    stat_chk(0, 0, 4'h1, "R1 q0 empty again");

    // R3 R4 fill, overflow
    for (int i = 0; i < 8; i++) push_msg(0, 0, {32'hC0DE_0000 + 32'(i), 64'(i * 3 + 7)}, 1);
    stat_chk(1, 0, 4'h2, "R3 full flag");
    push_msg(0, 0, 96'hBAD0_BAD0_BAD0_BAD0_BAD0_BAD0, 0);
    stat_chk(1, 0, 4'hA, "R4 overflow sticky");
    for (int i = 0; i < 8; i++) pop_chk(1, 0, "R4 contents after overflow");
    stat_chk(1, 0, 4'h9, "R4 overflow held when empty");
    bwr(1, 4'd0, 64'h8);
    stat_chk(1, 0, 4'h1, "R5 overflow clear");

    // R5 underflow
    pop_chk(1, 0, "R5 pop empty returns zero");
    stat_chk(0, 0, 4'h5, "R5 underflow sticky");
    bwr(0, 4'd0, 64'h4);
    stat_chk(0, 0, 4'h1, "R5 underflow clear");

    // R6 registered read data holds without a read
    brd(0, 4'd10, d);
    repeat (3) @(negedge clk);
    chk("R6 rdata hold", rdata[0], 64'd0);

    // R7 interrupts
    bwr(0, 4'd10, 64'hF);
    @(negedge clk);
    chk("R7 ap irq both empty", irq[0], 4'b0101);
    chk("R7 cp irq gated", irq[1], 4'b0000);
    push_msg(1, 1, 96'h7777_8888_9999_AAAA_BBBB_CCCC, 1);
    @(negedge clk);
    chk("R7 ap irq recv not empty", irq[0], 4'b1001);

    // R8 acknowledge dip then re-assert
    bwr(0, 4'd11, 64'h8);
    chk("R8 ack dip", irq[0], 4'b0001);
    @(negedge clk);
    chk("R8 re-assert", irq[0], 4'b1001);
    pop_chk(0, 1, "R1 q1 drain");

    // R10 concurrent commit (AP) and pop (CP) on queue 0
    push_msg(0, 0, 96'h0000_0001_0000_0002_0000_0003, 1);
    push_msg(0, 0, 96'h0000_0004_0000_0005_0000_0006, 1);
    bwr(0, 4'd2, 64'h0123_4567_89AB_CDEF);
    @(negedge clk);
    req[0] = 1'b1; we[0] = 1'b1; addr[0] = 4'd3; wdata[0] = 64'h0000_0000_1357_9BDF;
    req[1] = 1'b1; we[1] = 1'b0; addr[1] = 4'd4;
    @(posedge clk);
    @(negedge clk);
    req[0] = 1'b0; we[0] = 1'b0; req[1] = 1'b0;
    chk("R10 concurrent pop head", rdata[1], 64'h0000_0001_0000_0002);
    brd(1, 4'd5, d);
    chk("R10 concurrent pop lo", d, 64'h0000_0003);
    void'(q0.pop_front());
    q0.push_back(96'h0123_4567_89AB_CDEF_1357_9BDF);
    pop_chk(1, 0, "R10 order after concurrent 1");
    pop_chk(1, 0, "R10 order after concurrent 2");
    stat_chk(1, 0, 4'h1, "R10 empty after drain");

    // R10 both sides commit to queue 0 in one cycle: AP wins
    bwr(0, 4'd2, 64'hAAAA_AAAA_AAAA_AAAA);
    bwr(1, 4'd2, 64'hBBBB_BBBB_BBBB_BBBB);
    @(negedge clk);
    req[0] = 1'b1; we[0] = 1'b1; addr[0] = 4'd3; wdata[0] = 64'h1;
    req[1] = 1'b1; we[1] = 1'b1; addr[1] = 4'd3; wdata[1] = 64'h2;
    @(posedge clk);
    @(negedge clk);
    req[0] = 1'b0; we[0] = 1'b0; req[1] = 1'b0; we[1] = 1'b0;
    q0.push_back({64'hAAAA_AAAA_AAAA_AAAA, 32'h1});
    pop_chk(1, 0, "R10 AP wins double commit");
    stat_chk(1, 0, 4'h1, "R10 single entry no overflow");

    // R9 build without enable register
    chk("R9 lines always enabled", irq[2], 4'b0101);
    brd(2, 4'd10, d);
    chk("R9 enable reads all ones", d, 64'hF);
    bwr(2, 4'd10, 64'h0);
    @(negedge clk);
    chk("R9 enable write ignored", irq[2], 4'b0101);

    summary();
    $finish;
  end
endmodule